// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address by walking in-memory translation structures. A walk starts from a single-cycle `start_i` pulse. When the matching relocation enable is off, the block answers at once with a direct mapping. Otherwise it:

- picks a process context from the top two address bits;
- reads a process-table entry;
- descends a radix tree of up to a parameterized number of levels, each level carrying its own index width.

At the leaf it forms the real address and the page-size exponent. It then asks an external permission checker for the rights on the leaf entry. If the access is allowed, it marks the entry as referenced (and, for a store, as changed), writing the entry back only when a bit actually changed. The outcome is a one-cycle `done_o` or `fault_o` pulse. A fault carries a cause vector and, for data accesses, the faulting effective address.

All memory traffic uses one 64-bit port with two channels.

- **Request channel.** Each request is held stable until `mem_req_ready_i` is seen high at a clock edge. A request is either a doubleword read or a doubleword write.
- **Read response channel.** Each read is answered on this channel. A response is consumed on a cycle where `mem_rsp_valid_i` and `mem_rsp_ready_o` are both high. Writes complete at their request handshake and have no response.

The environment may stall either channel for any number of cycles. At most one read is outstanding.

The inputs `ea_i`, `acc_i`, `ir_en_i`, `dr_en_i`, `pid_i` and `ptab_i` must stay stable from the start pulse until the walk ends. `perm_i` is a combinational function of `leaf_o` and the access type.

Top module: `radix_walker`

## Requirements
- R1: When the relocation enable for the access is 0, the walk ends with `done_o` one cycle after start, with no memory request. Access `acc_i` is 0 for read, 1 for write and 2 for fetch; fetch uses `ir_en_i` and the others use `dr_en_i`. In this case `real_addr_o` is `ea_i` with bits 63:60 cleared, `grant_o` is 3'b111 and `page_exp_o` is 12.
- R2: With relocation on, `ea_i[63:62]` chooses the context. Value 0 uses `pid_i` and value 3 uses PID 0. Values 1 and 2 end with a fault whose cause is bit 4 for a fetch or bit 5 otherwise, with no memory request.
- R3: The process-table entry is read at `(ptab_i & 0x00FF_FFFF_FFFF_F000) + PID*16`. If PID*16 is at or above 2^(`ptab_i[4:0]`+12), the walk ends with a no-entry fault (cause bit 0) before any read.
- R4: The process-table doubleword supplies three fields:
  - the root base, `e & 0x00FF_FFFF_FFFF_FF00`;
  - the root index width, `e[4:0]`;
  - the initial size exponent, `e[61:56]`.

  At each level, an index width below 5, or above the current exponent, ends the walk with a bad-configuration fault (cause bit 2).
- R5: At each level the entry is read at base + 8 × ((EA' >> (exp − width)) mod 2^width), where EA' is `ea_i` with bits 63:62 cleared. The exponent then drops by the width.
- R6: A tree entry with bit 63 clear ends the walk with a no-entry fault (cause bit 0).
- R7: A valid entry with bit 62 clear is a directory. It gives the next base (`e & 0x00FF_FFFF_FFFF_FF00`) and the next width (`e[4:0]`). A directory found at level 5 ends with a bad-configuration fault.
- R8: At a leaf (bits 63 and 62 set), `real_addr_o` combines two parts. The bits of `e & 0x00FF_FFFF_FFFF_F000` at and above the remaining exponent are kept. The bits of EA' below that exponent fill the rest. `page_exp_o` is the remaining exponent and `leaf_addr_o` is the leaf's address.
- R9: `perm_i` bit 0 grants read, bit 1 grants write and bit 2 grants fetch. If the bit needed by the access is clear, the walk ends with a protection fault (cause bit 1).
- R10: On a permitted access, the leaf gets bit 8 (reference) set, and bit 7 (change) set on a write. The leaf is written back to `leaf_addr_o` only if it changed, and `leaf_o` shows the updated value.
- R11: `grant_o` equals `perm_i`, except that bit 1 is cleared for reads and fetches.
- R12: Storage faults (cause bits 0, 1, 2) add bit 3 when the access is a write. For data accesses, every fault reports `fault_ea_o = ea_i`; for fetches it reports 0. `done_o` leaves the cause at 0.
- R13: `done_o` and `fault_o` are one-cycle, mutually exclusive pulses. `start_i` is ignored while a walk is in progress and in the pulse cycle.
- R14: A memory request holds its valid, address, direction and data until accepted. Stalls on either channel change only the latency, not the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (single-cycle pulse) |
| ea_i | input | 64 | Effective address |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| ir_en_i | input | 1 | Instruction relocation enable |
| dr_en_i | input | 1 | Data relocation enable |
| pid_i | input | PID_W | Process identifier |
| ptab_i | input | 64 | Process-table base and size field |
| perm_i | input | 3 | Rights from the permission checker for `leaf_o` |
| leaf_o | output | 64 | Current leaf entry |
| leaf_addr_o | output | 64 | Address of the leaf entry |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_write_o | output | 1 | Request is a write |
| mem_req_addr_o | output | 64 | Request address |
| mem_req_wdata_o | output | 64 | Write data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker accepts read data |
| mem_rsp_data_i | input | 64 | Read data |
| done_o | output | 1 | Successful translation pulse |
| fault_o | output | 1 | Fault pulse |
| cause_o | output | 6 | Fault cause vector |
| fault_ea_o | output | 64 | Faulting effective address (data accesses) |
| real_addr_o | output | 64 | Translated real address |
| page_exp_o | output | EXP_W | Page-size exponent |
| grant_o | output | 3 | Granted rights |

## Verification
A wrong exponent or base register shows at the ports on the very next request: the read address of the following level moves, and the final real address and page exponent are off. A wrong level counter shows as a fault at a depth other than five. A wrong reference or change update shows as a write-back that is missing, extra, or carries wrong bits, within one cycle of the leaf check. A stuck state machine shows as a missing or doubled `done_o`/`fault_o` pulse, or as a request that drops before its handshake.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

  localparam int XLEN = 64;
  localparam int CAUSE_W = 6;

  // cause vector bit positions
  localparam int C_NOENT  = 0;
  localparam int C_PROT   = 1;
  localparam int C_BADCFG = 2;
  localparam int C_STORE  = 3;
  localparam int C_ISEG   = 4;
  localparam int C_DSEG   = 5;

  // entry bit positions
  localparam int B_VALID = 63;
  localparam int B_LEAF  = 62;
  localparam int B_REF   = 8;
  localparam int B_CHG   = 7;

  localparam logic [XLEN-1:0] DIR_BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [XLEN-1:0] PAGE_MASK     = 64'h00FF_FFFF_FFFF_F000;
  localparam logic [XLEN-1:0] REAL_MODE_MASK = 64'h0FFF_FFFF_FFFF_FFFF;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PT_REQ,
    S_PT_RSP,
    S_LV_CHK,
    S_LV_REQ,
    S_LV_RSP,
    S_LEAF,
    S_WB_REQ
  } walk_st_t;

  function automatic logic [2:0] needed_right(input logic [1:0] acc);
    case (acc)
      ACC_WRITE: needed_right = 3'b010;
      ACC_FETCH: needed_right = 3'b100;
      default:   needed_right = 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/radix_ctx_select.sv
module radix_ctx_select
  import radix_walk_pkg::*;
#(
  parameter int PID_W = 32
) (
  input  logic [XLEN-1:0]  ea,
  input  logic [1:0]       acc,
  input  logic             ir_en,
  input  logic             dr_en,
  input  logic [PID_W-1:0] pid_reg,
  input  logic [XLEN-1:0]  ptab_reg,
  output logic             real_mode,
  output logic             seg_fault,
  output logic             pt_oob,
  output logic [XLEN-1:0]  pt_addr
);
  logic [1:0]       quad;
  logic [PID_W-1:0] pid_sel;
  logic [XLEN-1:0]  offset;
  logic [6:0]       pt_exp;
  logic             unused_ptab;

  assign quad      = ea[63:62];
  assign real_mode = (acc == ACC_FETCH) ? !ir_en : !dr_en;
  assign seg_fault = (quad == 2'd1) || (quad == 2'd2);
  assign pid_sel   = (quad == 2'd3) ? '0 : pid_reg;

  always_comb begin
    offset = '0;
    offset[PID_W+3:4] = pid_sel;
  end

  assign pt_exp  = {2'b00, ptab_reg[4:0]} + 7'd12;
  assign pt_oob  = (offset >> pt_exp) != '0;
  assign pt_addr = (ptab_reg & PAGE_MASK) + offset;

  assign unused_ptab = ^{ptab_reg[63:56], ptab_reg[11:5]};
endmodule

// File: rtl/radix_level_calc.sv
module radix_level_calc
  import radix_walk_pkg::*;
#(
  parameter int EXP_W = 7
) (
  input  logic [XLEN-1:0]  ea_tree,
  input  logic [XLEN-1:0]  base,
  input  logic [EXP_W-1:0] size_exp,
  input  logic [4:0]       width,
  output logic [XLEN-1:0]  ent_addr,
  output logic             cfg_bad
);
  logic [EXP_W-1:0] w_ext;
  logic [EXP_W-1:0] shamt;
  logic [XLEN-1:0]  idx;

  assign w_ext    = EXP_W'(width);
  assign cfg_bad  = (width < 5'd5) || (w_ext > size_exp);
  assign shamt    = size_exp - w_ext;
  assign idx      = (ea_tree >> shamt) & ((64'd1 << width) - 64'd1);
  assign ent_addr = base + (idx << 3);
endmodule

// File: rtl/radix_leaf_form.sv
module radix_leaf_form
  import radix_walk_pkg::*;
#(
  parameter int EXP_W = 7
) (
  input  logic [XLEN-1:0]  leaf,
  input  logic [XLEN-1:0]  ea_tree,
  input  logic [EXP_W-1:0] size_exp,
  input  logic [1:0]       acc,
  input  logic [2:0]       perm,
  output logic [XLEN-1:0]  real_addr,
  output logic             denied,
  output logic [XLEN-1:0]  new_entry,
  output logic             changed,
  output logic [2:0]       rights
);
  logic [XLEN-1:0] low_mask;
  logic            is_write;

  assign is_write  = (acc == ACC_WRITE);
  assign denied    = (needed_right(acc) & ~perm) != 3'b000;
  assign low_mask  = (64'd1 << size_exp) - 64'd1;
  assign real_addr = ((leaf & PAGE_MASK) & ~low_mask) | (ea_tree & low_mask);

  always_comb begin
    new_entry = leaf;
    new_entry[B_REF] = 1'b1;
    if (is_write) new_entry[B_CHG] = 1'b1;
  end

  assign changed = (new_entry != leaf);
  assign rights  = is_write ? perm : (perm & 3'b101);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int PID_W         = 32,
  parameter int MAX_LEVELS    = 5,
  parameter int EXP_W         = 7,
  parameter int REAL_PAGE_EXP = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [63:0]        ea_i,
  input  logic [1:0]         acc_i,
  input  logic               ir_en_i,
  input  logic               dr_en_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic [63:0]        ptab_i,
  input  logic [2:0]         perm_i,
  output logic [63:0]        leaf_o,
  output logic [63:0]        leaf_addr_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic               mem_req_write_o,
  output logic [63:0]        mem_req_addr_o,
  output logic [63:0]        mem_req_wdata_o,
  input  logic               mem_rsp_valid_i,
  output logic               mem_rsp_ready_o,
  input  logic [63:0]        mem_rsp_data_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [5:0]         cause_o,
  output logic [63:0]        fault_ea_o,
  output logic [63:0]        real_addr_o,
  output logic [EXP_W-1:0]   page_exp_o,
  output logic [2:0]         grant_o
);
  localparam int LVL_W = $clog2(MAX_LEVELS + 1);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

  walk_st_t         st, st_n;
  logic [XLEN-1:0]  ea_q, base_q, ent_addr_q, leaf_q, leaf_addr_q;
  logic [1:0]       acc_q;
  logic [4:0]       width_q;
  logic [EXP_W-1:0] exp_q;
  logic [LVL_W-1:0] lvl_q;
  logic [XLEN-1:0]  ea_tree;

  logic             done_q, fault_q;
  logic [5:0]       cause_q;
  logic [XLEN-1:0]  fault_ea_q, real_q;
  logic [EXP_W-1:0] pexp_q;
  logic [2:0]       grant_q;

  // context decode (used when accepting a start)
  logic             cx_real, cx_seg, cx_oob;
  logic [XLEN-1:0]  cx_pt_addr;

  radix_ctx_select #(.PID_W(PID_W)) ctx_i (
    .ea(ea_i), .acc(acc_i), .ir_en(ir_en_i), .dr_en(dr_en_i),
    .pid_reg(pid_i), .ptab_reg(ptab_i),
    .real_mode(cx_real), .seg_fault(cx_seg), .pt_oob(cx_oob),
    .pt_addr(cx_pt_addr)
  );

  assign ea_tree = {2'b00, ea_q[61:0]};

  logic [XLEN-1:0] lv_addr;
  logic            lv_bad;

  radix_level_calc #(.EXP_W(EXP_W)) lvl_i (
    .ea_tree(ea_tree), .base(base_q), .size_exp(exp_q), .width(width_q),
    .ent_addr(lv_addr), .cfg_bad(lv_bad)
  );

  logic [XLEN-1:0] lf_real, lf_new;
  logic            lf_denied, lf_changed;
  logic [2:0]      lf_rights;

  radix_leaf_form #(.EXP_W(EXP_W)) leaf_i (
    .leaf(leaf_q), .ea_tree(ea_tree), .size_exp(exp_q), .acc(acc_q),
    .perm(perm_i), .real_addr(lf_real), .denied(lf_denied),
    .new_entry(lf_new), .changed(lf_changed), .rights(lf_rights)
  );

  // next-state and event decode
  logic       accept, fin, flt, storage;
  logic [5:0] fbits;
  logic [1:0] cur_acc;
  logic [XLEN-1:0] cur_ea;
  logic       rsp_take;

  assign cur_acc  = (st == S_IDLE) ? acc_i : acc_q;
  assign cur_ea   = (st == S_IDLE) ? ea_i : ea_q;
  assign rsp_take = mem_rsp_valid_i && mem_rsp_ready_o;

  always_comb begin
    st_n    = st;
    accept  = 1'b0;
    fin     = 1'b0;
    flt     = 1'b0;
    storage = 1'b1;
    fbits   = '0;
    case (st)
      S_IDLE: begin
        if (start_i && !done_q && !fault_q) begin
          accept = 1'b1;
          if (cx_real) begin
            fin = 1'b1;
          end else if (cx_seg) begin
            flt = 1'b1;
            storage = 1'b0;
            if (acc_i == ACC_FETCH) fbits[C_ISEG] = 1'b1;
            else                    fbits[C_DSEG] = 1'b1;
          end else if (cx_oob) begin
            flt = 1'b1;
            fbits[C_NOENT] = 1'b1;
          end else begin
            st_n = S_PT_REQ;
          end
        end
      end
      S_PT_REQ: if (mem_req_ready_i) st_n = S_PT_RSP;
      S_PT_RSP: if (rsp_take) st_n = S_LV_CHK;
      S_LV_CHK: begin
        if (lv_bad) begin
          flt = 1'b1;
          fbits[C_BADCFG] = 1'b1;
        end else begin
          st_n = S_LV_REQ;
        end
      end
      S_LV_REQ: if (mem_req_ready_i) st_n = S_LV_RSP;
      S_LV_RSP: begin
        if (rsp_take) begin
          if (!mem_rsp_data_i[B_VALID]) begin
            flt = 1'b1;
            fbits[C_NOENT] = 1'b1;
          end else if (mem_rsp_data_i[B_LEAF]) begin
            st_n = S_LEAF;
          end else if (lvl_q == LAST_LVL) begin
            flt = 1'b1;
            fbits[C_BADCFG] = 1'b1;
          end else begin
            st_n = S_LV_CHK;
          end
        end
      end
      S_LEAF: begin
        if (lf_denied) begin
          flt = 1'b1;
          fbits[C_PROT] = 1'b1;
        end else if (lf_changed) begin
          st_n = S_WB_REQ;
        end else begin
          fin = 1'b1;
        end
      end
      S_WB_REQ: if (mem_req_ready_i) fin = 1'b1;
      default: st_n = S_IDLE;
    endcase
    if (flt && storage && (cur_acc == ACC_WRITE)) fbits[C_STORE] = 1'b1;
    if (fin || flt) st_n = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ea_q        <= '0;
      acc_q       <= ACC_READ;
      base_q      <= '0;
      width_q     <= '0;
      exp_q       <= '0;
      lvl_q       <= '0;
      ent_addr_q  <= '0;
      leaf_q      <= '0;
      leaf_addr_q <= '0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      cause_q     <= '0;
      fault_ea_q  <= '0;
      real_q      <= '0;
      pexp_q      <= '0;
      grant_q     <= '0;
    end else begin
      st      <= st_n;
      done_q  <= fin;
      fault_q <= flt;

      if (accept) begin
        ea_q       <= ea_i;
        acc_q      <= acc_i;
        lvl_q      <= '0;
        ent_addr_q <= cx_pt_addr;
        if (cx_real) begin
          real_q  <= ea_i & REAL_MODE_MASK;
          grant_q <= 3'b111;
          pexp_q  <= EXP_W'(REAL_PAGE_EXP);
        end
      end

      if (st == S_PT_RSP && rsp_take) begin
        base_q  <= mem_rsp_data_i & DIR_BASE_MASK;
        width_q <= mem_rsp_data_i[4:0];
        exp_q   <= EXP_W'(mem_rsp_data_i[61:56]);
      end

      if (st == S_LV_CHK && !lv_bad) ent_addr_q <= lv_addr;

      if (st == S_LV_RSP && rsp_take && mem_rsp_data_i[B_VALID]) begin
        exp_q <= exp_q - EXP_W'(width_q);
        if (mem_rsp_data_i[B_LEAF]) begin
          leaf_q      <= mem_rsp_data_i;
          leaf_addr_q <= ent_addr_q;
        end else begin
          base_q  <= mem_rsp_data_i & DIR_BASE_MASK;
          width_q <= mem_rsp_data_i[4:0];
          lvl_q   <= lvl_q + 1'b1;
        end
      end

      if (st == S_LEAF && !lf_denied) begin
        leaf_q  <= lf_new;
        real_q  <= lf_real;
        grant_q <= lf_rights;
        pexp_q  <= exp_q;
      end

      if (flt) begin
        cause_q    <= fbits;
        fault_ea_q <= (cur_acc == ACC_FETCH) ? '0 : cur_ea;
      end else if (fin) begin
        cause_q    <= '0;
        fault_ea_q <= '0;
      end
    end
  end

  logic unused_rsp;
  assign unused_rsp = ^mem_rsp_data_i[7:5];

  // memory port
  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_write_o = 1'b0;
    mem_req_addr_o  = ent_addr_q;
    case (st)
      S_PT_REQ, S_LV_REQ: mem_req_valid_o = 1'b1;
      S_WB_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_write_o = 1'b1;
        mem_req_addr_o  = leaf_addr_q;
      end
      default: ;
    endcase
  end

  assign mem_req_wdata_o = leaf_q;
  assign mem_rsp_ready_o = (st == S_PT_RSP) || (st == S_LV_RSP);

  assign leaf_o      = leaf_q;
  assign leaf_addr_o = leaf_addr_q;
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign cause_o     = cause_q;
  assign fault_ea_o  = fault_ea_q;
  assign real_addr_o = real_q;
  assign page_exp_o  = pexp_q;
  assign grant_o     = grant_q;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk
  import radix_walk_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic        mem_req_write_o,
  input logic [63:0] mem_req_addr_o,
  input logic [63:0] mem_req_wdata_o,
  input logic        done_o,
  input logic        fault_o,
  input logic [5:0]  cause_o
);
  assert_req_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o
      && $stable(mem_req_addr_o) && $stable(mem_req_write_o)
      && $stable(mem_req_wdata_o));

  assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !fault_o);

  assert_fault_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o && !done_o);

  assert_done_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cause_o == 6'd0);

  assert_fault_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (cause_o != 6'd0)
      && !(cause_o[C_STORE] && (cause_o[C_ISEG] || cause_o[C_DSEG])));

  assert_wb_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_write_o |-> mem_req_wdata_o[B_REF]
      && mem_req_wdata_o[B_VALID] && mem_req_wdata_o[B_LEAF]);
endmodule

bind radix_walker radix_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o),
  .done_o(done_o), .fault_o(fault_o), .cause_o(cause_o)
);

// File: tb/radix_walker_tb_top.sv
module radix_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_i = 1'b0;
  logic [63:0] ea_i = '0;
  logic [1:0]  acc_i = 2'd0;
  logic        ir_en_i = 1'b1, dr_en_i = 1'b1;
  logic [31:0] pid_i = 32'd1;
  logic [63:0] ptab_i = 64'h10000;
  logic [2:0]  perm_i = 3'b111;
  logic [63:0] leaf_o, leaf_addr_o, mem_req_addr_o, mem_req_wdata_o;
  logic        mem_req_valid_o, mem_req_ready_i, mem_req_write_o;
  logic        mem_rsp_valid_i = 1'b0, mem_rsp_ready_o;
  logic [63:0] mem_rsp_data_i = '0;
  logic        done_o, fault_o;
  logic [5:0]  cause_o;
  logic [63:0] fault_ea_o, real_addr_o;
  logic [6:0]  page_exp_o;
  logic [2:0]  grant_o;

  radix_walker dut_i (.*);

  // memory model
  logic [63:0] mem [logic [63:0]];
  int rd_cnt = 0, wr_cnt = 0;
  logic [63:0] last_wr_addr = '0, last_wr_data = '0;
  logic stall_en = 1'b0;
  logic [3:0] stall_cnt = '0;
  assign mem_req_ready_i = !stall_en || (stall_cnt[0] ^ stall_cnt[2]);

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 1'b1;
    if (!rst_n) mem_rsp_valid_i <= 1'b0;
    else begin
      if (mem_rsp_valid_i && mem_rsp_ready_o) mem_rsp_valid_i <= 1'b0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (mem_req_write_o) begin
          mem[mem_req_addr_o] = mem_req_wdata_o;
          wr_cnt = wr_cnt + 1;
          last_wr_addr = mem_req_addr_o;
          last_wr_data = mem_req_wdata_o;
        end else begin
          rd_cnt = rd_cnt + 1;
          mem_rsp_valid_i <= 1'b1;
          mem_rsp_data_i  <= mem.exists(mem_req_addr_o) ? mem[mem_req_addr_o] : 64'd0;
        end
      end
    end
  end

  int n_chk = 0, n_err = 0;
  logic got_done, got_fault;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic walk(input logic [63:0] ea, input logic [1:0] acc);
    @(negedge clk);
    ea_i = ea; acc_i = acc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 5000 && !(done_o || fault_o); i++) @(negedge clk);
    got_done = done_o; got_fault = fault_o;
    if (!(done_o || fault_o)) chk("R13 walk timeout", 64'd0, 64'd1);
    @(negedge clk);
  endtask

  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h4000_0000_0000_0000;
  localparam logic [63:0] EA_M = 64'h0000_0000_1234_5678;
  logic [63:0] l1a, l2a, leaf0;

  task automatic setup_tables();
    mem[64'h10010] = (64'd30 << 56) | 64'h20000 | 64'd9;
    l1a = 64'h20000 + (((EA_M >> 21) & 64'h1FF) << 3);
    mem[l1a] = V | 64'h30000 | 64'd9;
    l2a = 64'h30000 + (((EA_M >> 12) & 64'h1FF) << 3);
    leaf0 = V | L | 64'hABCD_E000;
    mem[l2a] = leaf0;
    // quadrant 3 context (pid 0): one-level large page
    mem[64'h10000] = (64'd30 << 56) | 64'h40000 | 64'd9;
    // pid 3: five directories; pid 4: four directories then a leaf
    mem[64'h10030] = (64'd60 << 56) | 64'h50000 | 64'd5;
    mem[64'h10040] = (64'd60 << 56) | 64'h60000 | 64'd5;
    for (int k = 0; k < 5; k++) begin
      mem[64'h50000 + 64'(k) * 64'h1000] = V | (64'h51000 + 64'(k) * 64'h1000) | 64'd5;
      if (k < 4) mem[64'h60000 + 64'(k) * 64'h1000] = V | (64'h61000 + 64'(k) * 64'h1000) | 64'd5;
    end
    mem[64'h64000] = V | L | (64'd1 << 8) | 64'h8_0000_0000;
  endtask

  task automatic t_reset();
    chk("R13 reset done", {63'd0, done_o}, 64'd0);
    chk("R13 reset fault", {63'd0, fault_o}, 64'd0);
    chk("R14 reset req", {63'd0, mem_req_valid_o}, 64'd0);
  endtask

  task automatic t_real();
    int r0 = rd_cnt;
    dr_en_i = 1'b0;
    walk(64'hF123_4567_89AB_CDEF, 2'd0);
    chk("R1 real done", {63'd0, got_done}, 64'd1);
    chk("R1 real addr", real_addr_o, 64'h0123_4567_89AB_CDEF);
    chk("R1 real grant", {61'd0, grant_o}, 64'd7);
    chk("R1 real exp", {57'd0, page_exp_o}, 64'd12);
    dr_en_i = 1'b1; ir_en_i = 1'b0;
    walk(64'hA000_0000_0000_1000, 2'd2);
    chk("R1 fetch real addr", real_addr_o, 64'h0000_0000_0000_1000);
    chk("R1 no memory access", 64'(rd_cnt - r0), 64'd0);
    ir_en_i = 1'b1;
  endtask

  task automatic t_seg();
    walk(64'h4000_0000_0000_1000, 2'd0);
    chk("R2 dseg cause", {58'd0, cause_o}, 64'h20);
    chk("R12 dseg ea", fault_ea_o, 64'h4000_0000_0000_1000);
    walk(64'h8000_0000_0000_2000, 2'd2);
    chk("R2 iseg cause", {58'd0, cause_o}, 64'h10);
    chk("R12 fetch ea zero", fault_ea_o, 64'd0);
    walk(64'h4000_0000_0000_0000, 2'd1);
    chk("R12 seg no store bit", {58'd0, cause_o}, 64'h20);
  endtask

  task automatic t_main();
    int w0 = wr_cnt;
    perm_i = 3'b111;
    walk(EA_M, 2'd0);
    chk("R8 done", {63'd0, got_done}, 64'd1);
    chk("R8 real", real_addr_o, 64'hABCD_E000 | (EA_M & 64'hFFF));
    chk("R8 exp", {57'd0, page_exp_o}, 64'd12);
    chk("R8 leaf addr", leaf_addr_o, l2a);
    chk("R11 read drops write", {61'd0, grant_o}, 64'd5);
    chk("R10 wb count", 64'(wr_cnt - w0), 64'd1);
    chk("R10 wb addr", last_wr_addr, l2a);
    chk("R10 wb data ref", last_wr_data, leaf0 | (64'd1 << 8));
    chk("R10 leaf out", leaf_o, leaf0 | (64'd1 << 8));
    walk(EA_M, 2'd0);
    chk("R10 no wb when unchanged", 64'(wr_cnt - w0), 64'd1);
    walk(EA_M, 2'd1);
    chk("R10 store sets change", last_wr_data, leaf0 | (64'd1 << 8) | (64'd1 << 7));
    chk("R11 write grant", {61'd0, grant_o}, 64'd7);
    dr_en_i = 1'b0;
    walk(EA_M, 2'd2);
    chk("R1 fetch uses ir enable", real_addr_o, 64'hABCD_E000 | (EA_M & 64'hFFF));
    dr_en_i = 1'b1;
  endtask

  task automatic t_prot();
    perm_i = 3'b101;
    walk(EA_M, 2'd1);
    chk("R9 write denied", {58'd0, cause_o}, 64'h0A);
    chk("R12 store ea", fault_ea_o, EA_M);
    perm_i = 3'b011;
    walk(EA_M, 2'd2);
    chk("R9 fetch denied", {58'd0, cause_o}, 64'h02);
    chk("R12 fetch fault ea", fault_ea_o, 64'd0);
    perm_i = 3'b111;
  endtask

  task automatic t_bounds();
    walk(EA_M + 64'h1000, 2'd0);
    chk("R6 invalid entry", {58'd0, cause_o}, 64'h01);
    pid_i = 32'd256;
    walk(EA_M, 2'd1);
    chk("R3 oob cause", {58'd0, cause_o}, 64'h09);
    pid_i = 32'd255;
    walk(EA_M, 2'd0);
    chk("R4 in-range empty entry badcfg", {58'd0, cause_o}, 64'h04);
    pid_i = 32'h7777;
    walk(64'hC000_0000_0040_1234, 2'd0);
    chk("R2 quad3 pid0 done", {63'd0, got_done}, 64'd0 | 64'(got_fault ? 0 : 1));
    pid_i = 32'd1;
  endtask

  task automatic t_quad3();
    mem[64'h40000 + ((64'h0040_1234 >> 21) << 3)] = V | L | (64'd1 << 8) | 64'h7_0000_0000;
    pid_i = 32'h7777;
    walk(64'hC000_0000_0040_1234, 2'd0);
    chk("R2 quad3 done", {63'd0, got_done}, 64'd1);
    chk("R5 large page real", real_addr_o, 64'h7_0000_0000 | (64'h0040_1234 & 64'h1F_FFFF));
    chk("R5 large page exp", {57'd0, page_exp_o}, 64'd21);
    pid_i = 32'd1;
  endtask

  task automatic t_depth();
    int r0 = rd_cnt;
    pid_i = 32'd3;
    walk(64'd0, 2'd0);
    chk("R7 depth limit cause", {58'd0, cause_o}, 64'h04);
    chk("R7 depth reads", 64'(rd_cnt - r0), 64'd6);
    pid_i = 32'd4;
    walk(64'd0, 2'd0);
    chk("R7 leaf at level five", {63'd0, got_done}, 64'd1);
    chk("R8 deep exp", {57'd0, page_exp_o}, 64'd35);
    chk("R8 deep real", real_addr_o, 64'h8_0000_0000);
    pid_i = 32'd1;
  endtask

  task automatic t_stall_busy();
    stall_en = 1'b1;
    @(negedge clk);
    ea_i = EA_M; acc_i = 2'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    ea_i = 64'h4000_0000_0000_0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; ea_i = EA_M;
    for (int i = 0; i < 5000 && !(done_o || fault_o); i++) @(negedge clk);
    chk("R13 busy start ignored", {63'd0, done_o}, 64'd1);
    chk("R14 stalled result", real_addr_o, 64'hABCD_E000 | (EA_M & 64'hFFF));
    @(negedge clk);
    chk("R13 no second pulse", {62'd0, done_o, fault_o}, 64'd0);
    stall_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    setup_tables();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_real();
    t_seg();
    t_main();
    t_prot();
    t_bounds();
    t_quad3();
    t_depth();
    t_stall_busy();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule